// File: doc/BRIEF.md
# Dual-Policy Shadow Tag Directory

This block is the tag directory of a set-associative cache whose eviction choice adapts between two replacement policies. Next to the real tag array it keeps two shadow tag arrays of identical geometry. One shadow is run as least-recently-used and the other as least-frequently-used. Every reference is looked up in, and updates, all three arrays in the same cycle, whichever policy is active at the time. The block reports whether each shadow would have hit, so that a selector elsewhere can compare their miss behaviour.

On a real miss the real array picks its victim so that its contents follow the shadow named by the policy-select input. After that shadow has handled the same reference, the victim is a real way whose tag the shadow no longer holds. If every real tag is still present in the shadow, the real array falls back to its own least-recently-used way. In all three arrays, empty ways are filled before any valid way is evicted. Address splitting is done upstream, with 64-byte lines assumed. Data storage and refill are also handled elsewhere. The default associativity is 4, and 2-way and 8-way builds use the same parameter.

Top module: `dual_policy_tag_dir`

## Requirements
- R1: A request sampled with `req_valid` high at a rising edge produces `rsp_valid` high in the following cycle, and all results for that request are registered outputs in that same cycle.
- R2: Both shadow arrays are looked up and updated on every request, independent of `pol_sel`.
- R3: When a set is full, the LRU shadow replaces the way whose last reference (hit or fill) is oldest.
- R4: The LFU shadow keeps a 4-bit saturating count per way. A fill sets the count to 1, a hit adds 1 and stops at 15, and on a full set a miss replaces the lowest count, with ties going to the lowest way index.
- R5: In every array, a miss in a set that still has invalid ways fills the lowest-numbered invalid way.
- R6: On a real miss in a full set, `fill_way` is the lowest-numbered real way whose tag is absent from the selected shadow's set after that shadow has processed the same request (`pol_sel` 0 selects LRU, 1 selects LFU). If no such way exists, `fill_way` is the real array's LRU way.
- R7: On a real hit, `real_hit` is 1, `fill_way` is the way that holds the tag, no tag changes, and that way becomes the most recently used in the real array.
- R8: Reset invalidates every tag and clears every count. The first request to any set afterwards misses in all three arrays and fills way 0, and all outputs are 0 while reset is held.
- R9: In a cycle without a response, `rsp_valid`, `real_hit`, `lru_hit`, `lfu_hit` and `fill_way` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_set | input | $clog2(SETS) | Set index of the reference |
| req_tag | input | TAG_W | Tag of the reference |
| pol_sel | input | 1 | Policy the real array follows: 0 LRU, 1 LFU |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| real_hit | output | 1 | Reference hit in the real array |
| fill_way | output | $clog2(WAYS) | Hit way on a real hit, replaced way on a real miss |
| lru_hit | output | 1 | Reference hit in the LRU shadow |
| lfu_hit | output | 1 | Reference hit in the LFU shadow |

## Verification
All five results of a request are due exactly one clock after the rising edge that samples it, because each output passes through a single register stage. The bench drives a request on a falling edge and runs its behavioural model at that moment. At the next falling edge, one full cycle later, it compares every output with the model before it drives the following request. Directed checks of fill order, victim choice under each policy and counter saturation sample at that same falling edge.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

  typedef enum logic {
    POL_LRU = 1'b0,
    POL_LFU = 1'b1
  } repl_pol_e;

endpackage

// File: rtl/dpt_way_array.sv
// One set-associative tag array with its replacement state.
// POLICY picks recency ages or saturating reference counts.
// EXPORT_NEXT picks whether the addressed row is exported before or after this access.
module dpt_way_array #(
  parameter int                WAYS        = 4,
  parameter int                SETS        = 16,
  parameter int                TAG_W       = 20,
  parameter int                CNT_W       = 4,
  parameter dpt_pkg::repl_pol_e POLICY     = dpt_pkg::POL_LRU,
  parameter bit                EXPORT_NEXT = 1'b1,
  localparam int               WAY_W       = $clog2(WAYS),
  localparam int               SET_W       = $clog2(SETS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_en,
  input  logic [SET_W-1:0]            acc_set,
  input  logic [TAG_W-1:0]            acc_tag,
  input  logic                        alt_valid,
  input  logic [WAY_W-1:0]            alt_way,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            way_o,
  output logic [WAYS-1:0][TAG_W-1:0]  row_tag_o,
  output logic [WAYS-1:0]             row_val_o
);

  localparam int META_W = (POLICY == dpt_pkg::POL_LFU) ? CNT_W : WAY_W;

  logic [WAYS-1:0][TAG_W-1:0]  tag_q  [SETS];
  logic [WAYS-1:0]             val_q  [SETS];
  logic [WAYS-1:0][META_W-1:0] meta_q [SETS];

  logic [WAYS-1:0][TAG_W-1:0]  row_tag, tag_nxt;
  logic [WAYS-1:0]             row_val, val_nxt;
  logic [WAYS-1:0][META_W-1:0] row_meta, meta_nxt, meta_rst;
  logic                        hit_any, inv_any;
  logic [WAY_W-1:0]            hit_way, inv_way, pol_victim, sel_way;

  // Lookup of the addressed row
  always_comb begin
    row_tag  = tag_q[acc_set];
    row_val  = val_q[acc_set];
    row_meta = meta_q[acc_set];
    hit_any  = 1'b0;
    hit_way  = '0;
    inv_any  = 1'b0;
    inv_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (row_val[w] && (row_tag[w] == acc_tag)) begin
        hit_any = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!row_val[w]) begin
        inv_any = 1'b1;
        inv_way = WAY_W'(w);
      end
    end
  end

  // Way selection: hit, else empty way, else forced choice, else policy victim
  always_comb begin
    if (hit_any) begin
      sel_way = hit_way;
    end else if (inv_any) begin
      sel_way = inv_way;
    end else if (alt_valid) begin
      sel_way = alt_way;
    end else begin
      sel_way = pol_victim;
    end
  end

  // Tag and valid next state for the addressed row
  always_comb begin
    tag_nxt = row_tag;
    val_nxt = row_val;
    if (!hit_any) begin
      tag_nxt[sel_way] = acc_tag;
      val_nxt[sel_way] = 1'b1;
    end
  end

  generate
    if (POLICY == dpt_pkg::POL_LRU) begin : g_lru
      logic [META_W-1:0] ref_age;

      always_comb begin
        for (int w = 0; w < WAYS; w++) begin
          meta_rst[w] = META_W'(w);
        end
      end

      // Oldest way carries the largest age
      always_comb begin
        pol_victim = '0;
        for (int w = 0; w < WAYS; w++) begin
          if (row_meta[w] == META_W'(WAYS - 1)) begin
            pol_victim = WAY_W'(w);
          end
        end
      end

      // Touched way becomes age 0; younger ways age by one
      always_comb begin
        ref_age  = row_meta[sel_way];
        meta_nxt = row_meta;
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == sel_way) begin
            meta_nxt[w] = '0;
          end else if (row_meta[w] < ref_age) begin
            meta_nxt[w] = row_meta[w] + 1'b1;
          end
        end
      end
    end else begin : g_lfu
      logic [META_W-1:0] best;

      always_comb begin
        meta_rst = '0;
      end

      // Smallest count wins, lower index wins ties
      always_comb begin
        best       = row_meta[0];
        pol_victim = '0;
        for (int w = 1; w < WAYS; w++) begin
          if (row_meta[w] < best) begin
            best       = row_meta[w];
            pol_victim = WAY_W'(w);
          end
        end
      end

      always_comb begin
        meta_nxt = row_meta;
        if (hit_any) begin
          if (row_meta[sel_way] != {META_W{1'b1}}) begin
            meta_nxt[sel_way] = row_meta[sel_way] + 1'b1;
          end
        end else begin
          meta_nxt[sel_way] = META_W'(1);
        end
      end
    end

    if (EXPORT_NEXT) begin : g_exp_next
      assign row_tag_o = tag_nxt;
      assign row_val_o = val_nxt;
    end else begin : g_exp_cur
      assign row_tag_o = row_tag;
      assign row_val_o = row_val;
    end
  endgenerate

  assign hit_o = hit_any;
  assign way_o = sel_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]  <= '0;
        val_q[s]  <= '0;
        meta_q[s] <= meta_rst;
      end
    end else if (acc_en) begin
      tag_q[acc_set]  <= tag_nxt;
      val_q[acc_set]  <= val_nxt;
      meta_q[acc_set] <= meta_nxt;
    end
  end

endmodule

// File: rtl/dpt_absent_pick.sv
// Finds the lowest real way holding a tag the reference shadow row does not contain.
module dpt_absent_pick #(
  parameter int  WAYS  = 4,
  parameter int  TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] real_tag,
  input  logic [WAYS-1:0]            real_val,
  input  logic [WAYS-1:0][TAG_W-1:0] ref_tag,
  input  logic [WAYS-1:0]            ref_val,
  output logic                       found_o,
  output logic [WAY_W-1:0]           way_o
);

  logic [WAYS-1:0] absent;

  genvar r;
  generate
    for (r = 0; r < WAYS; r++) begin : g_real
      logic [WAYS-1:0] match;
      for (genvar k = 0; k < WAYS; k++) begin : g_ref
        assign match[k] = ref_val[k] && (ref_tag[k] == real_tag[r]);
      end
      assign absent[r] = real_val[r] && (match == '0);
    end
  endgenerate

  always_comb begin
    found_o = 1'b0;
    way_o   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (absent[w]) begin
        found_o = 1'b1;
        way_o   = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/dual_policy_tag_dir.sv
module dual_policy_tag_dir #(
  parameter int  WAYS  = 4,
  parameter int  SETS  = 16,
  parameter int  TAG_W = 20,
  parameter int  CNT_W = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [SET_W-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             pol_sel,
  output logic             rsp_valid,
  output logic             real_hit,
  output logic [WAY_W-1:0] fill_way,
  output logic             lru_hit,
  output logic             lfu_hit
);

  logic                       s_lru_hit, s_lfu_hit, r_hit;
  logic [WAY_W-1:0]           unused_lru_way, unused_lfu_way, r_way;
  logic [WAYS-1:0][TAG_W-1:0] lru_row_tag, lfu_row_tag, sel_row_tag, real_row_tag;
  logic [WAYS-1:0]            lru_row_val, lfu_row_val, sel_row_val, real_row_val;
  logic                       alt_found;
  logic [WAY_W-1:0]           alt_way;

  logic             rsp_valid_d, real_hit_d, lru_hit_d, lfu_hit_d;
  logic [WAY_W-1:0] fill_way_d;

  dpt_way_array #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .CNT_W(CNT_W),
    .POLICY(dpt_pkg::POL_LRU), .EXPORT_NEXT(1'b1)
  ) u_shadow_lru (
    .clk(clk), .rst_n(rst_n), .acc_en(req_valid), .acc_set(req_set), .acc_tag(req_tag),
    .alt_valid(1'b0), .alt_way('0),
    .hit_o(s_lru_hit), .way_o(unused_lru_way),
    .row_tag_o(lru_row_tag), .row_val_o(lru_row_val)
  );

  dpt_way_array #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .CNT_W(CNT_W),
    .POLICY(dpt_pkg::POL_LFU), .EXPORT_NEXT(1'b1)
  ) u_shadow_lfu (
    .clk(clk), .rst_n(rst_n), .acc_en(req_valid), .acc_set(req_set), .acc_tag(req_tag),
    .alt_valid(1'b0), .alt_way('0),
    .hit_o(s_lfu_hit), .way_o(unused_lfu_way),
    .row_tag_o(lfu_row_tag), .row_val_o(lfu_row_val)
  );

  // Real array follows the shadow named by pol_sel, seen after this access
  always_comb begin
    if (pol_sel == dpt_pkg::POL_LFU) begin
      sel_row_tag = lfu_row_tag;
      sel_row_val = lfu_row_val;
    end else begin
      sel_row_tag = lru_row_tag;
      sel_row_val = lru_row_val;
    end
  end

  dpt_absent_pick #(.WAYS(WAYS), .TAG_W(TAG_W)) u_absent (
    .real_tag(real_row_tag), .real_val(real_row_val),
    .ref_tag(sel_row_tag), .ref_val(sel_row_val),
    .found_o(alt_found), .way_o(alt_way)
  );

  dpt_way_array #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .CNT_W(CNT_W),
    .POLICY(dpt_pkg::POL_LRU), .EXPORT_NEXT(1'b0)
  ) u_real (
    .clk(clk), .rst_n(rst_n), .acc_en(req_valid), .acc_set(req_set), .acc_tag(req_tag),
    .alt_valid(alt_found), .alt_way(alt_way),
    .hit_o(r_hit), .way_o(r_way),
    .row_tag_o(real_row_tag), .row_val_o(real_row_val)
  );

  // Response next state
  always_comb begin
    rsp_valid_d = req_valid;
    real_hit_d  = req_valid & r_hit;
    lru_hit_d   = req_valid & s_lru_hit;
    lfu_hit_d   = req_valid & s_lfu_hit;
    fill_way_d  = req_valid ? r_way : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      real_hit  <= 1'b0;
      lru_hit   <= 1'b0;
      lfu_hit   <= 1'b0;
      fill_way  <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      real_hit  <= real_hit_d;
      lru_hit   <= lru_hit_d;
      lfu_hit   <= lfu_hit_d;
      fill_way  <= fill_way_d;
    end
  end

endmodule

// File: rtl/dual_policy_tag_dir_chk.sv
module dual_policy_tag_dir_chk #(
  parameter int  WAYS  = 4,
  parameter int  SETS  = 16,
  parameter int  TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [SET_W-1:0] req_set,
  input logic [TAG_W-1:0] req_tag,
  input logic             rsp_valid,
  input logic             real_hit,
  input logic [WAY_W-1:0] fill_way,
  input logic             lru_hit,
  input logic             lfu_hit
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);  // R1

  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);  // R1

  AST_REPEAT_HITS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid) && (req_set == $past(req_set)) && (req_tag == $past(req_tag)))
    |=> (real_hit && lru_hit && lfu_hit));  // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!real_hit && !lru_hit && !lfu_hit && (fill_way == '0)));  // R9

endmodule

bind dual_policy_tag_dir dual_policy_tag_dir_chk #(
  .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set), .req_tag(req_tag),
  .rsp_valid(rsp_valid), .real_hit(real_hit), .fill_way(fill_way),
  .lru_hit(lru_hit), .lfu_hit(lfu_hit)
);

// File: tb/dual_policy_tag_dir_bench.sv
`timescale 1ns/1ps
module dual_policy_tag_dir_bench;

  localparam int WAYS    = 4;
  localparam int SETS    = 16;
  localparam int TAG_W   = 20;
  localparam int CNT_W   = 4;
  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid;
  logic [SET_W-1:0] req_set;
  logic [TAG_W-1:0] req_tag;
  logic             pol_sel;
  logic             rsp_valid, real_hit, lru_hit, lfu_hit;
  logic [WAY_W-1:0] fill_way;

  always #2.5 clk = ~clk;

  dual_policy_tag_dir #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .CNT_W(CNT_W))
  u_dual_policy_tag_dir (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set), .req_tag(req_tag),
    .pol_sel(pol_sel), .rsp_valid(rsp_valid), .real_hit(real_hit), .fill_way(fill_way),
    .lru_hit(lru_hit), .lfu_hit(lfu_hit)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string cur_rq = "R8";

  // Reference model: index 0 LRU shadow, 1 LFU shadow, 2 real array
  int     m_tag   [3][SETS][WAYS];
  bit     m_val   [3][SETS][WAYS];
  longint m_stamp [3][SETS][WAYS];
  int     m_cnt   [SETS][WAYS];
  longint now;
  int     exp_valid, exp_hit, exp_way, exp_lru, exp_lfu;

  task automatic chk(string rq, string what, int got, int expv);
    n_cmp++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s %s got %0d expected %0d", rq, what, got, expv);
    end
  endtask

  function automatic void model_clear();
    for (int a = 0; a < 3; a++)
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          m_val[a][s][w]   = 1'b0;
          m_tag[a][s][w]   = 0;
          m_stamp[a][s][w] = 0;
          if (a == 0) m_cnt[s][w] = 0;
        end
    now = 1;
  endfunction

  function automatic int find_hit(int a, int s, int t);
    for (int w = 0; w < WAYS; w++)
      if (m_val[a][s][w] && m_tag[a][s][w] == t) return w;
    return -1;
  endfunction

  function automatic int first_inv(int a, int s);
    for (int w = 0; w < WAYS; w++)
      if (!m_val[a][s][w]) return w;
    return -1;
  endfunction

  function automatic int oldest(int a, int s);
    int o = 0;
    for (int w = 1; w < WAYS; w++)
      if (m_stamp[a][s][w] < m_stamp[a][s][o]) o = w;
    return o;
  endfunction

  function automatic void place(int a, int s, int w, int t);
    m_tag[a][s][w]   = t;
    m_val[a][s][w]   = 1'b1;
    m_stamp[a][s][w] = now;
  endfunction

  function automatic void model_ref(int s, int t, bit p);
    int h;
    int w;
    h = find_hit(0, s, t);
    exp_lru = (h >= 0);
    if (h >= 0) m_stamp[0][s][h] = now;
    else begin
      w = first_inv(0, s);
      if (w < 0) w = oldest(0, s);
      place(0, s, w, t);
    end
    h = find_hit(1, s, t);
    exp_lfu = (h >= 0);
    if (h >= 0) begin
      if (m_cnt[s][h] < CNT_MAX) m_cnt[s][h]++;
    end else begin
      w = first_inv(1, s);
      if (w < 0) begin
        w = 0;
        for (int k = 1; k < WAYS; k++) if (m_cnt[s][k] < m_cnt[s][w]) w = k;
      end
      place(1, s, w, t);
      m_cnt[s][w] = 1;
    end
    h = find_hit(2, s, t);
    exp_hit = (h >= 0);
    if (h >= 0) begin
      m_stamp[2][s][h] = now;
      exp_way = h;
    end else begin
      w = first_inv(2, s);
      if (w < 0)
        for (int k = 0; k < WAYS; k++)
          if (w < 0 && find_hit(p ? 1 : 0, s, m_tag[2][s][k]) < 0) w = k;
      if (w < 0) w = oldest(2, s);
      place(2, s, w, t);
      exp_way = w;
    end
    now++;
  endfunction

  // Compare the previous request's results, then drive the next one
  task automatic step(bit v, int s, int t, bit p, string rq);
    @(negedge clk);
    chk(cur_rq, "rsp_valid (R1)", int'(rsp_valid), exp_valid);
    chk(cur_rq, "real_hit (R7)", int'(real_hit), exp_hit);
    chk(cur_rq, "fill_way (R6)", int'(fill_way), exp_way);
    chk(cur_rq, "lru_hit (R3)", int'(lru_hit), exp_lru);
    chk(cur_rq, "lfu_hit (R4)", int'(lfu_hit), exp_lfu);
    req_valid = v;
    req_set   = SET_W'(s);
    req_tag   = TAG_W'(t);
    pol_sel   = p;
    if (v) begin
      exp_valid = 1;
      model_ref(s, t, p);
    end else begin
      exp_valid = 0; exp_hit = 0; exp_way = 0; exp_lru = 0; exp_lfu = 0;
    end
    cur_rq = rq;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_set = '0; req_tag = '0; pol_sel = 1'b0;
    exp_valid = 0; exp_hit = 0; exp_way = 0; exp_lru = 0; exp_lfu = 0;
    model_clear();
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R8");
    @(negedge clk) rst_n = 1'b1;
    step(0, 0, 0, 0, "R9");

    // R5 / R8: empty set fills ways in index order, first access misses everywhere
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 100 + i, 0, "R5");
      if (i > 0) chk("R5", "fill_way order", int'(fill_way), i - 1);
    end
    step(0, 0, 0, 0, "R9");
    chk("R8", "first fill after reset hit", int'(real_hit), 0);
    chk("R5", "fill_way order", int'(fill_way), 3);
    step(0, 0, 0, 0, "R9");
    chk("R9", "idle rsp_valid", int'(rsp_valid), 0);

    // R7: hit returns the holding way
    step(1, 0, 102, 0, "R7");
    step(0, 0, 0, 0, "R9");
    chk("R7", "hit flag", int'(real_hit), 1);
    chk("R7", "hit way", int'(fill_way), 2);

    // R6: LFU selected, victim differs from LRU choice
    for (int i = 0; i < 4; i++) step(1, 1, 10 + i, 1, "R6");
    for (int i = 0; i < 3; i++) step(1, 1, 10, 1, "R6");
    for (int i = 1; i < 4; i++) step(1, 1, 10 + i, 1, "R6");
    step(1, 1, 14, 1, "R6");
    step(0, 0, 0, 0, "R9");
    chk("R6", "LFU-following victim", int'(fill_way), 1);
    // Same pattern with LRU selected
    for (int i = 0; i < 4; i++) step(1, 2, 10 + i, 0, "R6");
    for (int i = 0; i < 3; i++) step(1, 2, 10, 0, "R6");
    for (int i = 1; i < 4; i++) step(1, 2, 10 + i, 0, "R6");
    step(1, 2, 14, 0, "R6");
    step(0, 0, 0, 0, "R9");
    chk("R6", "LRU-following victim", int'(fill_way), 0);

    // R4: counter saturates instead of wrapping
    step(1, 3, 20, 0, "R4");
    for (int i = 0; i < 15; i++) step(1, 3, 20, 0, "R4");
    for (int i = 1; i < 4; i++) step(1, 3, 20 + i, 0, "R4");
    step(1, 3, 24, 0, "R4");
    step(1, 3, 20, 0, "R4");
    step(0, 0, 0, 0, "R9");
    chk("R4", "saturated block kept", int'(lfu_hit), 1);

    // R2: policy select flips every request, both shadows tracked
    for (int i = 0; i < 200; i++) step(1, 4, i % 6, i[0], "R2");

    // R8: reset in the middle of traffic
    step(0, 0, 0, 0, "R8");
    rst_n = 1'b0;
    model_clear();
    step(0, 0, 0, 0, "R8");
    chk("R8", "outputs in reset", int'(rsp_valid), 0);
    @(negedge clk) rst_n = 1'b1;
    step(1, 4, 3, 0, "R8");
    step(0, 0, 0, 0, "R9");
    chk("R8", "miss after reset", int'(lru_hit | lfu_hit | real_hit), 0);
    chk("R8", "way 0 after reset", int'(fill_way), 0);

    // R3: mixed random traffic with periodic policy changes
    for (int i = 0; i < 4000; i++)
      step($urandom_range(0, 4) != 0, $urandom_range(0, 3), $urandom_range(0, 7),
           (i / 250) % 2 == 1, "R3");
    step(0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, "R9");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule